// File: doc/BRIEF.md
# Maintenance Response Packet Parser

The parser sits on the receive side of a packet endpoint and takes in maintenance read-response and write-response packets one 32-bit word at a time. Each word is offered on a simple bus handshake (cycle, strobe, address, data, acknowledge). The address chooses the kind of response: 0x82 carries a read response and 0x83 a write response. The parser takes the link and routing fields from the header words and keeps them in registers. For a read response it also rebuilds the payload into a small buffer of 32-bit words. The payload double-words arrive shifted by 16 bits across bus words, so each stored word is formed from the low half of the previous bus word and the high half of the current one.

Control is a two-state machine. In `ST_COLLECT` the parser acknowledges supported words, counts them and parses them. When the cycle signal falls after a packet that has all of its mandatory words, the transition *packet closed* moves it to `ST_HOLD`. There it raises the ready flag that matches the packet kind and acknowledges nothing. The transition *consumer done* returns it to `ST_COLLECT` when the consumer pulses `done`. A cycle that ends early drops the partial packet and no flag is raised. The consumer reads the payload buffer through an index port, one cycle after it presents the index.

Top module: `mrsp_parser`

## Requirements
- R1: After reset `bus_ack`, `rd_rsp_ready` and `wr_rsp_ready` are 0 and `pay_words` is 0.
- R2: In `ST_COLLECT` a word with `bus_cyc`, `bus_stb` high and address 0x82 or 0x83 is acknowledged. `bus_ack` is high for exactly one cycle and is low in the cycle after.
- R3: A word offered with any other address is never acknowledged, and it changes no field output.
- R4: Word 0 sets `vc` from bit 9, `crf` from bit 8, `prio` from bits 7:6 and `tt` from bits 5:4.
- R5: Word 1 sets `dst_id` and word 2 sets `src_id`, all 32 bits.
- R6: Word 3 sets `rsp_status` from bits 27:24, `tgt_tid` from bits 23:16 and `hop_count` from bits 15:8.
- R7: In a read response, buffer slot k holds {bits 15:0 of word 4+k, bits 31:16 of word 5+k}. This places double-word d at slots 2d (bits 63:32) and 2d+1 (bits 31:0).
- R8: `pay_words` counts the slots written in the current packet and stops at BUF_DEPTH. Words past the buffer capacity are acknowledged and do not change the buffer. The word counter stops at PKT_WORDS_MAX, and later words are still acknowledged.
- R9: When `bus_cyc` falls after a read response of at least 6 words, `rd_rsp_ready` rises in the next cycle. When it falls after a write response of at least 4 words, `wr_rsp_ready` rises instead. The two flags are never high together.
- R10: A ready flag stays high until `done` is sampled high, and it is low in the cycle after. While a flag is high no word is acknowledged. `done` in `ST_COLLECT` has no effect.
- R11: If `bus_cyc` falls before a packet has its mandatory words, no ready flag rises and the next packet is parsed from its word 0.
- R12: `pay_data` shows slot `pay_idx` one cycle after the index is presented.
- R13: A write response writes no buffer slot, and it leaves `pay_words` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_cyc | input | 1 | Packet in progress |
| bus_stb | input | 1 | Word valid |
| bus_adr | input | 8 | Packet kind selector |
| bus_dat | input | 32 | Packet word |
| bus_ack | output | 1 | Word accepted (one-cycle pulse) |
| done | input | 1 | Consumer finished with the held packet |
| rd_rsp_ready | output | 1 | Read response held |
| wr_rsp_ready | output | 1 | Write response held |
| vc | output | 1 | Virtual channel bit |
| crf | output | 1 | Critical request flag |
| prio | output | 2 | Priority |
| tt | output | 2 | Transport type |
| dst_id | output | 32 | Destination identifier |
| src_id | output | 32 | Source identifier |
| rsp_status | output | 4 | Response status |
| tgt_tid | output | 8 | Target transaction identifier |
| hop_count | output | 8 | Hop count |
| pay_words | output | $clog2(BUF_DEPTH+1) | Payload slots written |
| pay_idx | input | $clog2(BUF_DEPTH) | Buffer read index |
| pay_data | output | 32 | Buffer read data |

## Verification
The bench builds the parser with BUF_DEPTH set to 4 and PKT_WORDS_MAX set to 12. With a buffer of only two double-words, a three-double-word read response runs past capacity, so the dropped slots and the limit on `pay_words` can be tested. The low word limit lets a short packet drive the word counter into saturation, where later words must still be acknowledged. The same settings keep the full-buffer readback and the realignment checks short.

// File: rtl/mrsp_pkg.sv
package mrsp_pkg;

    typedef enum logic [0:0] {
        ST_COLLECT,
        ST_HOLD
    } mrsp_state_e;

    typedef enum logic [0:0] {
        KIND_READ,
        KIND_WRITE
    } mrsp_kind_e;

    localparam logic [7:0] ADR_READ_RSP  = 8'h82;
    localparam logic [7:0] ADR_WRITE_RSP = 8'h83;

    // word positions inside a response packet
    localparam int WORD_LINK       = 0;
    localparam int WORD_DST        = 1;
    localparam int WORD_SRC        = 2;
    localparam int WORD_INFO       = 3;
    localparam int WORD_FIRST_HALF = 4;
    localparam int WORD_FIRST_SLOT = 5;

    // last mandatory word of each packet kind
    localparam int RD_LAST_MANDATORY = 5;
    localparam int WR_LAST_MANDATORY = 3;

    typedef struct packed {
        logic       vc;
        logic       crf;
        logic [1:0] prio;
        logic [1:0] tt;
    } mrsp_link_t;

endpackage

// File: rtl/mrsp_ctrl.sv
module mrsp_ctrl
    import mrsp_pkg::*;
#(
    parameter int PKT_WORDS_MAX = 34,
    parameter int IDX_W         = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic [7:0]       bus_adr,
    input  logic             done,
    output logic             bus_ack,
    output logic             accept,
    output logic [IDX_W-1:0] word_idx,
    output mrsp_kind_e       kind,
    output logic             rd_ready,
    output logic             wr_ready
);

    mrsp_state_e      state_q, state_nx;
    logic             ack_q;
    logic [IDX_W-1:0] idx_q;
    mrsp_kind_e       kind_q;
    logic             complete_q;
    logic             adr_ok;
    logic             idx_at_max;
    logic             hits_mandatory;

    assign adr_ok     = (bus_adr == ADR_READ_RSP) || (bus_adr == ADR_WRITE_RSP);
    assign accept     = (state_q == ST_COLLECT) && bus_cyc && bus_stb && !ack_q && adr_ok;
    assign idx_at_max = (int'(idx_q) >= PKT_WORDS_MAX);

    assign hits_mandatory =
        ((kind_q == KIND_READ)  && (int'(idx_q) == RD_LAST_MANDATORY)) ||
        ((kind_q == KIND_WRITE) && (int'(idx_q) == WR_LAST_MANDATORY));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: packet closed, consumer done
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_COLLECT: if (!bus_cyc && complete_q) state_nx = ST_HOLD;
            ST_HOLD:    if (done)                   state_nx = ST_COLLECT;
        endcase
    end

    // state outputs
    always_comb begin
        rd_ready = 1'b0;
        wr_ready = 1'b0;
        unique case (state_q)
            ST_COLLECT: begin
                rd_ready = 1'b0;
                wr_ready = 1'b0;
            end
            ST_HOLD: begin
                rd_ready = (kind_q == KIND_READ);
                wr_ready = (kind_q == KIND_WRITE);
            end
        endcase
    end

    // handshake and word tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q      <= 1'b0;
            idx_q      <= '0;
            kind_q     <= KIND_READ;
            complete_q <= 1'b0;
        end else begin
            ack_q <= accept;

            if ((state_q == ST_COLLECT) && !bus_cyc) begin
                idx_q <= '0;
            end else if (accept && !idx_at_max) begin
                idx_q <= idx_q + 1'b1;
            end

            if (accept && (idx_q == '0)) begin
                kind_q <= (bus_adr == ADR_READ_RSP) ? KIND_READ : KIND_WRITE;
            end

            if ((state_q == ST_HOLD) && done) begin
                complete_q <= 1'b0;
            end else if (accept) begin
                if (idx_q == '0) begin
                    complete_q <= 1'b0;
                end else if (hits_mandatory) begin
                    complete_q <= 1'b1;
                end
            end
        end
    end

    assign bus_ack  = ack_q;
    assign word_idx = idx_q;
    assign kind     = kind_q;

endmodule

// File: rtl/mrsp_fields.sv
module mrsp_fields
    import mrsp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [IDX_W-1:0] word_idx,
    input  logic [31:0]      bus_dat,
    output mrsp_link_t       link,
    output logic [31:0]      dst_id,
    output logic [31:0]      src_id,
    output logic [3:0]       rsp_status,
    output logic [7:0]       tgt_tid,
    output logic [7:0]       hop_count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link       <= '0;
            dst_id     <= '0;
            src_id     <= '0;
            rsp_status <= '0;
            tgt_tid    <= '0;
            hop_count  <= '0;
        end else if (accept) begin
            case (int'(word_idx))
                WORD_LINK: begin
                    link.vc   <= bus_dat[9];
                    link.crf  <= bus_dat[8];
                    link.prio <= bus_dat[7:6];
                    link.tt   <= bus_dat[5:4];
                end
                WORD_DST:  dst_id <= bus_dat;
                WORD_SRC:  src_id <= bus_dat;
                WORD_INFO: begin
                    rsp_status <= bus_dat[27:24];
                    tgt_tid    <= bus_dat[23:16];
                    hop_count  <= bus_dat[15:8];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mrsp_realign.sv
module mrsp_realign
    import mrsp_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int IDX_W     = 6,
    parameter int SLOT_W    = 4,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [IDX_W-1:0]  word_idx,
    input  mrsp_kind_e        kind,
    input  logic [31:0]       bus_dat,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [31:0]       wr_data,
    output logic [CNT_W-1:0]  pay_words
);

    logic [15:0] carry_q;
    logic        carry_take;
    logic        in_window;

    assign carry_take = accept && (kind == KIND_READ) && (int'(word_idx) >= WORD_FIRST_HALF);
    assign in_window  = (int'(word_idx) >= WORD_FIRST_SLOT) &&
                        (int'(word_idx) <  WORD_FIRST_SLOT + BUF_DEPTH);

    assign wr_en   = accept && (kind == KIND_READ) && in_window;
    assign wr_slot = SLOT_W'(word_idx - IDX_W'(WORD_FIRST_SLOT));
    assign wr_data = {carry_q, bus_dat[31:16]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q   <= '0;
            pay_words <= '0;
        end else begin
            if (carry_take) begin
                carry_q <= bus_dat[15:0];
            end
            if (accept && (word_idx == '0)) begin
                pay_words <= '0;
            end else if (wr_en) begin
                pay_words <= pay_words + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mrsp_pay_buf.sv
module mrsp_pay_buf #(
    parameter int DEPTH  = 16,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [31:0]       wr_data,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [31:0]       rd_data
);

    logic [31:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= slot_q[rd_idx];
        end
    end

endmodule

// File: rtl/mrsp_parser.sv
module mrsp_parser
    import mrsp_pkg::*;
#(
    parameter int BUF_DEPTH     = 16,
    parameter int PKT_WORDS_MAX = 34
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_cyc,
    input  logic                           bus_stb,
    input  logic [7:0]                     bus_adr,
    input  logic [31:0]                    bus_dat,
    output logic                           bus_ack,
    input  logic                           done,
    output logic                           rd_rsp_ready,
    output logic                           wr_rsp_ready,
    output logic                           vc,
    output logic                           crf,
    output logic [1:0]                     prio,
    output logic [1:0]                     tt,
    output logic [31:0]                    dst_id,
    output logic [31:0]                    src_id,
    output logic [3:0]                     rsp_status,
    output logic [7:0]                     tgt_tid,
    output logic [7:0]                     hop_count,
    output logic [$clog2(BUF_DEPTH+1)-1:0] pay_words,
    input  logic [$clog2(BUF_DEPTH)-1:0]   pay_idx,
    output logic [31:0]                    pay_data
);

    localparam int IDX_W  = $clog2(PKT_WORDS_MAX + 1);
    localparam int SLOT_W = $clog2(BUF_DEPTH);
    localparam int CNT_W  = $clog2(BUF_DEPTH + 1);

    logic              accept;
    logic [IDX_W-1:0]  word_idx;
    mrsp_kind_e        kind;
    mrsp_link_t        link;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [31:0]       wr_data;

    mrsp_ctrl #(
        .PKT_WORDS_MAX (PKT_WORDS_MAX),
        .IDX_W         (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cyc  (bus_cyc),
        .bus_stb  (bus_stb),
        .bus_adr  (bus_adr),
        .done     (done),
        .bus_ack  (bus_ack),
        .accept   (accept),
        .word_idx (word_idx),
        .kind     (kind),
        .rd_ready (rd_rsp_ready),
        .wr_ready (wr_rsp_ready)
    );

    mrsp_fields #(
        .IDX_W (IDX_W)
    ) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .word_idx   (word_idx),
        .bus_dat    (bus_dat),
        .link       (link),
        .dst_id     (dst_id),
        .src_id     (src_id),
        .rsp_status (rsp_status),
        .tgt_tid    (tgt_tid),
        .hop_count  (hop_count)
    );

    mrsp_realign #(
        .BUF_DEPTH (BUF_DEPTH),
        .IDX_W     (IDX_W),
        .SLOT_W    (SLOT_W),
        .CNT_W     (CNT_W)
    ) u_realign (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .word_idx  (word_idx),
        .kind      (kind),
        .bus_dat   (bus_dat),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .pay_words (pay_words)
    );

    mrsp_pay_buf #(
        .DEPTH  (BUF_DEPTH),
        .SLOT_W (SLOT_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .rd_idx  (pay_idx),
        .rd_data (pay_data)
    );

    assign vc   = link.vc;
    assign crf  = link.crf;
    assign prio = link.prio;
    assign tt   = link.tt;

endmodule

// File: rtl/mrsp_parser_chk.sv
module mrsp_parser_chk #(
    parameter int BUF_DEPTH = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_cyc,
    input logic                           bus_stb,
    input logic [7:0]                     bus_adr,
    input logic                           bus_ack,
    input logic                           done,
    input logic                           rd_rsp_ready,
    input logic                           wr_rsp_ready,
    input logic [$clog2(BUF_DEPTH+1)-1:0] pay_words
);

    logic any_ready;
    assign any_ready = rd_rsp_ready || wr_rsp_ready;

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_bad_adr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_stb && !bus_ack && (bus_adr != 8'h82) && (bus_adr != 8'h83)) |=> !bus_ack);

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pay_words) <= BUF_DEPTH);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_rsp_ready && wr_rsp_ready));

    assert_ready_after_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_ready) |-> !$past(bus_cyc));

    assert_ready_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ready && !done) |=> any_ready);

    assert_ready_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ready && done) |=> !any_ready);

    assert_no_ack_when_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_ready |-> !bus_ack);

endmodule

bind mrsp_parser mrsp_parser_chk #(
    .BUF_DEPTH (BUF_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cyc      (bus_cyc),
    .bus_stb      (bus_stb),
    .bus_adr      (bus_adr),
    .bus_ack      (bus_ack),
    .done         (done),
    .rd_rsp_ready (rd_rsp_ready),
    .wr_rsp_ready (wr_rsp_ready),
    .pay_words    (pay_words)
);

// File: tb/mrsp_parser_bench.sv
module mrsp_parser_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BUF_DEPTH  = 4;
    localparam int PKT_MAX    = 12;
    localparam int SLOT_W     = $clog2(BUF_DEPTH);
    localparam int CNT_W      = $clog2(BUF_DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_cyc = 1'b0;
    logic              bus_stb = 1'b0;
    logic [7:0]        bus_adr = 8'h00;
    logic [31:0]       bus_dat = 32'h0;
    logic              bus_ack;
    logic              done = 1'b0;
    logic              rd_rsp_ready, wr_rsp_ready;
    logic              vc, crf;
    logic [1:0]        prio, tt;
    logic [31:0]       dst_id, src_id;
    logic [3:0]        rsp_status;
    logic [7:0]        tgt_tid, hop_count;
    logic [CNT_W-1:0]  pay_words;
    logic [SLOT_W-1:0] pay_idx = '0;
    logic [31:0]       pay_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrsp_parser #(
        .BUF_DEPTH     (BUF_DEPTH),
        .PKT_WORDS_MAX (PKT_MAX)
    ) u_mrsp_parser (
        .clk (clk), .rst_n (rst_n),
        .bus_cyc (bus_cyc), .bus_stb (bus_stb), .bus_adr (bus_adr),
        .bus_dat (bus_dat), .bus_ack (bus_ack), .done (done),
        .rd_rsp_ready (rd_rsp_ready), .wr_rsp_ready (wr_rsp_ready),
        .vc (vc), .crf (crf), .prio (prio), .tt (tt),
        .dst_id (dst_id), .src_id (src_id), .rsp_status (rsp_status),
        .tgt_tid (tgt_tid), .hop_count (hop_count),
        .pay_words (pay_words), .pay_idx (pay_idx), .pay_data (pay_data)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_word(input logic [7:0] adr, input logic [31:0] dat);
        bus_cyc = 1'b1;
        bus_stb = 1'b1;
        bus_adr = adr;
        bus_dat = dat;
        do @(negedge clk); while (!bus_ack);
    endtask

    task automatic close_pkt();
        bus_cyc = 1'b0;
        bus_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic check_slot(input string req, input int idx, input logic [31:0] exp);
        pay_idx = SLOT_W'(idx);
        @(negedge clk);
        check(req, $sformatf("slot %0d", idx), 64'(pay_data), 64'(exp));
    endtask

    function automatic logic [31:0] link_word(logic v, logic c, logic [1:0] p, logic [1:0] t);
        return {16'h0, 6'h0, v, c, p, t, 4'h8};
    endfunction

    // header then payload words for n double-words, then extra words
    task automatic send_read(input logic [31:0] lw, input logic [31:0] d, input logic [31:0] s,
                             input logic [3:0] st, input logic [7:0] tid, input logic [7:0] hop,
                             input logic [63:0] dw [3], input int n, input int extra);
        put_word(8'h82, lw);
        put_word(8'h82, d);
        put_word(8'h82, s);
        put_word(8'h82, {4'b0010, st, tid, hop, 8'h00});
        put_word(8'h82, {16'h0, dw[0][63:48]});
        for (int k = 0; k < n; k++) begin
            put_word(8'h82, dw[k][47:16]);
            if (k + 1 < n) put_word(8'h82, {dw[k][15:0], dw[k+1][63:48]});
            else           put_word(8'h82, {dw[k][15:0], 16'hC3C3});
        end
        for (int e = 0; e < extra; e++) put_word(8'h82, 32'hDEAD_0000 + 32'(e));
    endtask

    task automatic send_write(input logic [31:0] lw, input logic [31:0] d, input logic [31:0] s,
                              input logic [3:0] st, input logic [7:0] tid, input logic [7:0] hop);
        put_word(8'h83, lw);
        put_word(8'h83, d);
        put_word(8'h83, s);
        put_word(8'h83, {4'b0011, st, tid, hop, 8'h00});
        put_word(8'h83, 32'h0000_5A5A);
    endtask

    task automatic t_reset();
        check("R1", "ack", 64'(bus_ack), 64'd0);
        check("R1", "rd ready", 64'(rd_rsp_ready), 64'd0);
        check("R1", "wr ready", 64'(wr_rsp_ready), 64'd0);
        check("R1", "pay_words", 64'(pay_words), 64'd0);
    endtask

    task automatic t_read_basic();
        logic [63:0] dw [3];
        dw[0] = 64'h1111_2222_3333_4444;
        dw[1] = 64'h5555_6666_7777_8888;
        dw[2] = 64'h0;
        send_read(link_word(1'b1, 1'b0, 2'd2, 2'd1), 32'hA1B2_C3D4, 32'h0F1E_2D3C,
                  4'h0, 8'h5A, 8'hFF, dw, 2, 0);
        close_pkt();
        check("R2", "ack low after pulse", 64'(bus_ack), 64'd0);
        check("R9", "rd ready", 64'(rd_rsp_ready), 64'd1);
        check("R9", "wr ready", 64'(wr_rsp_ready), 64'd0);
        check("R4", "vc", 64'(vc), 64'd1);
        check("R4", "crf", 64'(crf), 64'd0);
        check("R4", "prio", 64'(prio), 64'd2);
        check("R4", "tt", 64'(tt), 64'd1);
        check("R5", "dst", 64'(dst_id), 64'hA1B2_C3D4);
        check("R5", "src", 64'(src_id), 64'h0F1E_2D3C);
        check("R6", "status", 64'(rsp_status), 64'h0);
        check("R6", "tid", 64'(tgt_tid), 64'h5A);
        check("R6", "hop", 64'(hop_count), 64'hFF);
        check("R8", "pay_words", 64'(pay_words), 64'd4);
        check_slot("R7", 0, dw[0][63:32]);
        check_slot("R7", 1, dw[0][31:0]);
        check_slot("R12", 2, dw[1][63:32]);
        check_slot("R12", 3, dw[1][31:0]);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 4; i++) begin
            bus_cyc = 1'b1; bus_stb = 1'b1; bus_adr = 8'h82; bus_dat = 32'hFFFF_FFFF;
            @(negedge clk);
            check("R10", "no ack while held", 64'(bus_ack), 64'd0);
            check("R10", "ready held", 64'(rd_rsp_ready), 64'd1);
        end
        close_pkt();
        check("R10", "dst unchanged while held", 64'(dst_id), 64'hA1B2_C3D4);
        pulse_done();
        check("R10", "ready released", 64'(rd_rsp_ready), 64'd0);
    endtask

    task automatic t_write();
        send_write(link_word(1'b0, 1'b1, 2'd3, 2'd2), 32'h0000_0042, 32'h0000_0099,
                   4'h7, 8'h33, 8'h01);
        close_pkt();
        check("R9", "wr ready", 64'(wr_rsp_ready), 64'd1);
        check("R9", "rd ready", 64'(rd_rsp_ready), 64'd0);
        check("R4", "crf", 64'(crf), 64'd1);
        check("R4", "prio", 64'(prio), 64'd3);
        check("R6", "status", 64'(rsp_status), 64'h7);
        check("R6", "tid", 64'(tgt_tid), 64'h33);
        check("R6", "hop", 64'(hop_count), 64'h01);
        check("R13", "pay_words", 64'(pay_words), 64'd0);
        check_slot("R13", 0, 32'h1111_2222);
        pulse_done();
        check("R10", "wr released", 64'(wr_rsp_ready), 64'd0);
    endtask

    task automatic t_unsupported();
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_adr = 8'h84; bus_dat = 32'h1234_5678;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R3", "no ack", 64'(bus_ack), 64'd0);
        end
        close_pkt();
        check("R3", "dst unchanged", 64'(dst_id), 64'h0000_0042);
        check("R3", "no ready", 64'(rd_rsp_ready | wr_rsp_ready), 64'd0);
    endtask

    task automatic t_incomplete();
        put_word(8'h82, link_word(1'b0, 1'b0, 2'd0, 2'd0));
        put_word(8'h82, 32'hBAD0_BAD0);
        put_word(8'h82, 32'hBAD1_BAD1);
        put_word(8'h82, 32'h2000_0000);
        close_pkt();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11", "no ready", 64'(rd_rsp_ready | wr_rsp_ready), 64'd0);
        end
        send_write(link_word(1'b1, 1'b1, 2'd1, 2'd3), 32'hCAFE_0001, 32'hCAFE_0002,
                   4'h2, 8'h44, 8'h09);
        close_pkt();
        check("R11", "wr ready after restart", 64'(wr_rsp_ready), 64'd1);
        check("R11", "dst from new word1", 64'(dst_id), 64'hCAFE_0001);
        check("R11", "src from new word2", 64'(src_id), 64'hCAFE_0002);
        pulse_done();
    endtask

    task automatic t_overflow();
        logic [63:0] dw [3];
        dw[0] = 64'hA0A1_A2A3_A4A5_A6A7;
        dw[1] = 64'hB0B1_B2B3_B4B5_B6B7;
        dw[2] = 64'hC0C1_C2C3_C4C5_C6C7;
        // 11 packet words plus 4 extra: counter saturates at PKT_MAX, all acked
        send_read(link_word(1'b0, 1'b0, 2'd1, 2'd0), 32'h0000_0777, 32'h0000_0888,
                  4'hF, 8'h01, 8'h02, dw, 3, 4);
        close_pkt();
        check("R8", "all words acked, rd ready", 64'(rd_rsp_ready), 64'd1);
        check("R8", "pay_words capped", 64'(pay_words), 64'(BUF_DEPTH));
        check_slot("R8", 0, dw[0][63:32]);
        check_slot("R8", 1, dw[0][31:0]);
        check_slot("R8", 2, dw[1][63:32]);
        check_slot("R8", 3, dw[1][31:0]);
        pulse_done();
    endtask

    task automatic t_done_idle();
        pulse_done();
        check("R10", "done idle no effect", 64'(rd_rsp_ready | wr_rsp_ready), 64'd0);
        check_slot("R10", 0, 32'hA0A1_A2A3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_hold();
        t_write();
        t_unsupported();
        t_incomplete();
        t_overflow();
        t_done_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule